// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache Controller

This block sits between a processor word port and a slower main memory that moves whole lines. It holds eight line frames, organised as four sets of two ways. Each line is eight 32-bit words. Every processor access is split into a tag, a set index and a word offset. The two ways of the selected set are compared in the same cycle, so a hit is answered on the next clock edge.

On a miss the controller picks a victim way. If that victim is dirty, it is first written back to memory as an eight-beat burst. The wanted line is then fetched as an eight-beat burst. For a read, the requested word is handed to the processor as soon as its beat arrives, while the rest of the line is still filling.

Writes are kept in the cache and mark the line dirty. The cache copy goes back to memory only when the line is evicted. A write that misses either allocates the line or goes straight to memory. The choice is made per access by a policy input.

Top module: `cache_wb_ctl`

## Requirements
- R1: After reset `cpu_busy`, `cpu_ack` and `mem_req` are low, and every line is invalid, so the first access to any address misses.
- R2: Address bits [4:2] select the word in a line, bits [6:5] select the set, and bits [31:7] form the tag. Two lines that share a set but have different tags can be resident at once, one per way. Lines in different sets do not disturb each other.
- R3: A request that finds a valid line with a matching tag in either way raises `cpu_ack` in the next cycle. For a read, `cpu_rdata` holds the word in that same cycle. `cpu_busy` stays low and no memory transfer takes place.
- R4: A read miss fetches the whole line from its line-aligned address in eight beats. `cpu_ack` rises with the requested word during the fill. Later reads anywhere in that line hit.
- R5: A burst holds `mem_req` high from start to end and moves one word per `mem_ack`, with beat k at word k of the line. `mem_addr` holds the line base and changes only after an acknowledged beat. `mem_req` is only high while `cpu_busy` is high.
- R6: A write hit updates the cached word, marks the line dirty and makes no memory transfer.
- R7: The victim is the lowest-numbered invalid way of the set. If both ways are valid, the victim is the least recently used way. Recency is updated on every hit and every fill.
- R8: Evicting a dirty line first writes all eight words to the old line address, with `mem_we` and `mem_wmask` high on every beat. Evicting a clean line writes nothing to memory.
- R9: With `cfg_wr_alloc` = 1, a write miss fetches the line, merges the written word and leaves the line dirty. `cpu_ack` rises when the merge completes, and later reads of that word hit and return the written value.
- R10: With `cfg_wr_alloc` = 0, a write miss sends an eight-beat write burst to the line address. `mem_wmask` is high only on the beat of the target word, which carries `cpu_wdata`. The cache contents are left unchanged, so a later read of that address misses.
- R11: `cpu_busy` rises in the cycle after a miss is accepted and stays high until the miss completes. Requests presented while `cpu_busy` is high are ignored and produce no `cpu_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_alloc | input | 1 | Write-miss policy: 1 allocate, 0 bypass to memory |
| cpu_req | input | 1 | Processor access request, taken when `cpu_busy` is low |
| cpu_we | input | 1 | 1 write, 0 read |
| cpu_addr | input | 32 | Byte address of the word |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ack` on reads |
| cpu_ack | output | 1 | One-cycle completion pulse for a request |
| cpu_busy | output | 1 | High while a miss is being handled |
| mem_req | output | 1 | Burst in progress |
| mem_we | output | 1 | Burst direction: 1 write to memory, 0 read |
| mem_wmask | output | 1 | Current write beat is to be stored |
| mem_addr | output | 32 | Line base address of the burst |
| mem_wdata | output | 32 | Write data of the current beat |
| mem_rdata | input | 32 | Read data of the current beat |
| mem_ack | input | 1 | Beat completes on this clock edge |

## Verification
The assertions take for granted that memory raises `mem_ack` only while `mem_req` is high. They also rely on the processor port being driven to known values from reset on. The bench meets both conditions. Its memory model acknowledges only an outstanding request, on alternate cycles. The processor driver holds `cpu_req` low outside its operations and releases the request at the first falling edge after acceptance. The one exception is the deliberate test that keeps a conflicting request asserted throughout a miss.

// File: rtl/cache_ctl_pkg.sv
package cache_ctl_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_EVICT  = 2'd1,
        SEQ_FILL   = 2'd2,
        SEQ_BYPASS = 2'd3
    } seq_st_t;
endpackage

// File: rtl/cache_tag_match.sv
module cache_tag_match #(
    parameter int TAG_W = 25,
    parameter int WAYS  = 2,
    localparam int WB   = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
    input  logic [WAYS-1:0]            way_valid,
    input  logic [TAG_W-1:0]           look_tag,
    output logic [WAYS-1:0]            hit_vec,
    output logic                       any_hit,
    output logic [WB-1:0]              hit_way
);
    // one comparator per way, all evaluated together
    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign hit_vec[g] = way_valid[g] && (way_tag[g] == look_tag);
    end

    assign any_hit = |hit_vec;

    always_comb begin
        hit_way = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (hit_vec[i]) hit_way = i[WB-1:0];
        end
    end
endmodule

// File: rtl/cache_victim_pick.sv
module cache_victim_pick #(
    parameter int WAYS = 2,
    localparam int WB  = $clog2(WAYS)
) (
    input  logic [WAYS-1:0] way_valid,
    input  logic [WB-1:0]   lru_way,
    output logic [WB-1:0]   victim
);
    // lowest invalid way wins; otherwise the least recently used one
    always_comb begin
        victim = lru_way;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!way_valid[i]) victim = i[WB-1:0];
        end
    end
endmodule

// File: rtl/cache_wb_ctl.sv
module cache_wb_ctl
    import cache_ctl_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 8,
    parameter int SETS       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_alloc,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              cpu_ack,
    output logic              cpu_busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_wmask,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    localparam int WAYS     = 2;  // single recency bit per set
    localparam int BYTE_OFF = $clog2(WORD_W / 8);
    localparam int WSEL_W   = $clog2(LINE_WORDS);
    localparam int OFF_W    = BYTE_OFF + WSEL_W;
    localparam int IDX_W    = $clog2(SETS);
    localparam int TAG_W    = ADDR_W - IDX_W - OFF_W;

    typedef struct packed {
        seq_st_t                                         st;
        logic [WSEL_W-1:0]                               beat;
        logic [ADDR_W-1:0]                               addr;
        logic                                            we;
        logic [WORD_W-1:0]                               wdata;
        logic                                            way;
        logic                                            ack;
        logic [WORD_W-1:0]                               rdata;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]            tag;
        logic [SETS-1:0][WAYS-1:0]                       valid;
        logic [SETS-1:0][WAYS-1:0]                       dirty;
        logic [SETS-1:0]                                 lru;
        logic [SETS-1:0][WAYS-1:0][LINE_WORDS-1:0][WORD_W-1:0] data;
    } regs_t;

    regs_t r_q, r_d;

    // fields of the incoming request
    logic [IDX_W-1:0]  in_idx;
    logic [TAG_W-1:0]  in_tag;
    logic [WSEL_W-1:0] in_wsel;
    assign in_idx  = cpu_addr[OFF_W +: IDX_W];
    assign in_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
    assign in_wsel = cpu_addr[BYTE_OFF +: WSEL_W];

    // fields of the captured request
    logic [IDX_W-1:0]  q_idx;
    logic [TAG_W-1:0]  q_tag;
    logic [WSEL_W-1:0] q_wsel;
    assign q_idx  = r_q.addr[OFF_W +: IDX_W];
    assign q_tag  = r_q.addr[ADDR_W-1 -: TAG_W];
    assign q_wsel = r_q.addr[BYTE_OFF +: WSEL_W];

    logic unused_low;
    assign unused_low = ^r_q.addr[BYTE_OFF-1:0];

    logic [WAYS-1:0] hit_vec;
    logic            any_hit;
    logic            hit_way;
    logic            victim;

    cache_tag_match #(.TAG_W(TAG_W), .WAYS(WAYS)) u_match (
        .way_tag  (r_q.tag[in_idx]),
        .way_valid(r_q.valid[in_idx]),
        .look_tag (in_tag),
        .hit_vec  (hit_vec),
        .any_hit  (any_hit),
        .hit_way  (hit_way)
    );

    cache_victim_pick #(.WAYS(WAYS)) u_victim (
        .way_valid(r_q.valid[in_idx]),
        .lru_way  (r_q.lru[in_idx]),
        .victim   (victim)
    );

    always_comb begin
        r_d     = r_q;
        r_d.ack = 1'b0;
        unique case (r_q.st)
            SEQ_IDLE: begin
                if (cpu_req) begin
                    r_d.addr  = cpu_addr;
                    r_d.we    = cpu_we;
                    r_d.wdata = cpu_wdata;
                    r_d.beat  = '0;
                    if (any_hit) begin
                        r_d.ack         = 1'b1;
                        r_d.lru[in_idx] = ~hit_way;
                        if (cpu_we) begin
                            r_d.data[in_idx][hit_way][in_wsel] = cpu_wdata;
                            r_d.dirty[in_idx][hit_way]         = 1'b1;
                        end else begin
                            r_d.rdata = r_q.data[in_idx][hit_way][in_wsel];
                        end
                    end else if (cpu_we && !cfg_wr_alloc) begin
                        r_d.st = SEQ_BYPASS;
                    end else begin
                        r_d.way = victim;
                        r_d.st  = (r_q.valid[in_idx][victim] && r_q.dirty[in_idx][victim])
                                  ? SEQ_EVICT : SEQ_FILL;
                    end
                end
            end
            SEQ_EVICT: begin
                if (mem_ack) begin
                    r_d.beat = r_q.beat + 1'b1;
                    if (r_q.beat == '1) r_d.st = SEQ_FILL;
                end
            end
            SEQ_FILL: begin
                if (mem_ack) begin
                    r_d.beat = r_q.beat + 1'b1;
                    r_d.data[q_idx][r_q.way][r_q.beat] = mem_rdata;
                    if (!r_q.we && r_q.beat == q_wsel) begin
                        r_d.rdata = mem_rdata;
                        r_d.ack   = 1'b1;
                    end
                    if (r_q.beat == '1) begin
                        r_d.st                    = SEQ_IDLE;
                        r_d.tag[q_idx][r_q.way]   = q_tag;
                        r_d.valid[q_idx][r_q.way] = 1'b1;
                        r_d.dirty[q_idx][r_q.way] = r_q.we;
                        r_d.lru[q_idx]            = ~r_q.way;
                        if (r_q.we) begin
                            r_d.data[q_idx][r_q.way][q_wsel] = r_q.wdata;
                            r_d.ack = 1'b1;
                        end
                    end
                end
            end
            SEQ_BYPASS: begin
                if (mem_ack) begin
                    r_d.beat = r_q.beat + 1'b1;
                    if (r_q.beat == '1) begin
                        r_d.st  = SEQ_IDLE;
                        r_d.ack = 1'b1;
                    end
                end
            end
            default: r_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cpu_busy  = (r_q.st != SEQ_IDLE);
    assign cpu_ack   = r_q.ack;
    assign cpu_rdata = r_q.rdata;
    assign mem_req   = (r_q.st != SEQ_IDLE);
    assign mem_we    = (r_q.st == SEQ_EVICT) || (r_q.st == SEQ_BYPASS);
    assign mem_wmask = (r_q.st == SEQ_EVICT) ||
                       ((r_q.st == SEQ_BYPASS) && (r_q.beat == q_wsel));
    assign mem_addr  = (r_q.st == SEQ_EVICT)
                       ? {r_q.tag[q_idx][r_q.way], q_idx, {OFF_W{1'b0}}}
                       : {q_tag, q_idx, {OFF_W{1'b0}}};
    assign mem_wdata = (r_q.st == SEQ_BYPASS) ? r_q.wdata
                                              : r_q.data[q_idx][r_q.way][r_q.beat];

    // R3: hit completes next cycle without stalling
    p_hit_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_busy && any_hit) |=> (cpu_ack && !cpu_busy));

    // R6: a write hit starts no memory transfer
    p_wr_hit_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_we && !cpu_busy && any_hit) |=> !mem_req);

    // R11: miss raises busy in the following cycle
    p_miss_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_busy && !any_hit) |=> cpu_busy);

    // R5: memory traffic only during a stall
    p_req_in_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> cpu_busy);

    // R5: burst address held until a beat is acknowledged
    p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> $stable(mem_addr));

    // R2: at most one way of a set matches
    p_single_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
endmodule

// File: tb/tb_cache_wb_ctl.sv
module tb_cache_wb_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_alloc = 1'b1;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_ack, cpu_busy;
    logic        mem_req, mem_we, mem_wmask;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata;
    logic        mem_ack;

    always #5 clk = ~clk;

    cache_wb_ctl dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_alloc(cfg_wr_alloc),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack),
        .cpu_busy(cpu_busy), .mem_req(mem_req), .mem_we(mem_we),
        .mem_wmask(mem_wmask), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    int checks = 0;
    int errors = 0;
    int wbeats = 0;
    int rbeats = 0;
    int mwrites = 0;

    logic [31:0] mem_words [0:255];
    logic [31:0] ref_words [0:255];

    typedef struct {
        bit          rd;
        logic [31:0] val;
        string       tag;
    } exp_t;
    exp_t expq[$];

    function automatic void check(bit ok, string rq, string what,
                                  logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endfunction

    // memory model: acknowledges every other cycle while a burst is open
    logic [2:0] mbeat;
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            mbeat   <= '0;
        end else if (mem_req && !mem_ack) begin
            mem_ack   <= 1'b1;
            mem_rdata <= mem_words[mem_addr[9:2] + {5'b0, mbeat}];
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
            mbeat   <= mbeat + 3'd1;
            if (mem_we) wbeats <= wbeats + 1;
            else        rbeats <= rbeats + 1;
            if (mem_we && mem_wmask) begin
                mwrites <= mwrites + 1;
                mem_words[mem_addr[9:2] + {5'b0, mbeat}] <= mem_wdata;
            end
        end
    end

    // monitor: pops one expected completion per acknowledge
    always @(negedge clk) begin
        if (rst_n && cpu_ack) begin
            if (expq.size() == 0) begin
                check(1'b0, "R11", "unexpected cpu_ack", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = expq.pop_front();
                if (e.rd) check(cpu_rdata == e.val, e.tag, "read data", cpu_rdata, e.val);
                else      check(1'b1, e.tag, "write ack", 32'd1, 32'd1);
            end
        end
    end

    task automatic do_op(input bit we, input logic [31:0] addr, input logic [31:0] wd,
                         input bit alloc, input bit exp_miss, input int exp_w,
                         input int exp_r, input int exp_m, input string rq);
        int w0 = wbeats;
        int r0 = rbeats;
        int m0 = mwrites;
        bit saw_busy = 1'b0;
        exp_t e;
        e.rd  = !we;
        e.val = ref_words[addr[9:2]];
        e.tag = rq;
        if (we) ref_words[addr[9:2]] = wd;
        expq.push_back(e);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd; cfg_wr_alloc = alloc;
        @(negedge clk);
        cpu_req = 1'b0;
        while (cpu_busy) begin
            saw_busy = 1'b1;
            @(negedge clk);
        end
        #1;
        check(saw_busy == exp_miss, rq, "stall seen", 32'(saw_busy), 32'(exp_miss));
        check(wbeats - w0 == exp_w, rq, "write beats", 32'(wbeats - w0), 32'(exp_w));
        check(rbeats - r0 == exp_r, rq, "read beats", 32'(rbeats - r0), 32'(exp_r));
        check(mwrites - m0 == exp_m, rq, "stored beats", 32'(mwrites - m0), 32'(exp_m));
        check(expq.size() == 0, rq, "ack count", 32'(expq.size()), 32'd0);
    endtask

    initial begin
        #2_000_000;
        check(1'b0, "R11", "watchdog expired", 32'd0, 32'd1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    localparam logic [31:0] LA = 32'h000, LB = 32'h080, LC = 32'h100,
                            LD = 32'h180, LE = 32'h020, LF = 32'h0A0;

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem_words[i] = 32'hC0DE_0000 + 32'(i * 3);
            ref_words[i] = 32'hC0DE_0000 + 32'(i * 3);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        check(!cpu_busy, "R1", "busy after reset", 32'(cpu_busy), 32'd0);
        check(!mem_req, "R1", "mem_req after reset", 32'(mem_req), 32'd0);
        check(!cpu_ack, "R1", "ack after reset", 32'(cpu_ack), 32'd0);

        // we, addr, wdata, alloc, miss, wbeats, rbeats, stored
        do_op(0, LA + 32'h08, 0, 1, 1, 0, 8, 0, "R1");   // cold miss, R4 fill
        do_op(0, LA + 32'h1C, 0, 1, 0, 0, 0, 0, "R3");   // R4: rest of line hits
        do_op(0, LB + 32'h04, 0, 1, 1, 0, 8, 0, "R7");   // invalid way taken
        do_op(0, LA + 32'h00, 0, 1, 0, 0, 0, 0, "R2");   // both tags resident in set 0
        do_op(0, LC + 32'h10, 0, 1, 1, 0, 8, 0, "R8");   // clean eviction of B
        do_op(0, LA + 32'h14, 0, 1, 0, 0, 0, 0, "R7");   // recency kept A
        do_op(1, LA + 32'h04, 32'h1111_2222, 1, 0, 0, 0, 0, "R6");
        check(mem_words[(LA + 32'h04) >> 2] != 32'h1111_2222, "R6", "memory untouched",
              mem_words[(LA + 32'h04) >> 2], 32'hC0DE_0003);
        do_op(0, LC + 32'h10, 0, 1, 0, 0, 0, 0, "R3");
        do_op(0, LB + 32'h0C, 0, 1, 1, 8, 8, 8, "R8");   // dirty A written back
        check(mem_words[(LA + 32'h04) >> 2] == 32'h1111_2222, "R8", "written-back word",
              mem_words[(LA + 32'h04) >> 2], 32'h1111_2222);
        do_op(1, LD + 32'h0C, 32'h3333_4444, 0, 1, 8, 0, 1, "R10");
        check(mem_words[(LD + 32'h0C) >> 2] == 32'h3333_4444, "R10", "bypass word",
              mem_words[(LD + 32'h0C) >> 2], 32'h3333_4444);
        check(mem_words[(LD + 32'h08) >> 2] == 32'hC0DE_0000 + 32'(((LD + 32'h08) >> 2) * 3),
              "R10", "masked neighbour", mem_words[(LD + 32'h08) >> 2],
              32'hC0DE_0000 + 32'(((LD + 32'h08) >> 2) * 3));
        do_op(0, LD + 32'h0C, 0, 1, 1, 0, 8, 0, "R10");  // not allocated: misses
        do_op(1, LE + 32'h10, 32'h5555_6666, 1, 1, 0, 8, 0, "R9");
        do_op(0, LE + 32'h10, 0, 1, 0, 0, 0, 0, "R9");

        // R11: conflicting request held high during a miss is ignored
        begin
            exp_t e;
            e.rd = 1'b1; e.val = ref_words[(LF + 32'h08) >> 2]; e.tag = "R11";
            expq.push_back(e);
            @(negedge clk);
            cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = LF + 32'h08;
            @(negedge clk);
            cpu_we = 1'b1; cpu_addr = LE + 32'h10; cpu_wdata = 32'hDEAD_BEEF;
            check(cpu_busy, "R11", "busy after miss", 32'(cpu_busy), 32'd1);
            while (cpu_busy) @(negedge clk);
            cpu_req = 1'b0; cpu_we = 1'b0;
            #1;
            check(expq.size() == 0, "R11", "single ack", 32'(expq.size()), 32'd0);
        end
        do_op(0, LE + 32'h10, 0, 1, 0, 0, 0, 0, "R11");  // still the old value
        do_op(0, LB + 32'h1C, 0, 1, 0, 0, 0, 0, "R2");
        do_op(0, LF + 32'h1C, 0, 1, 0, 0, 0, 0, "R4");

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule